// File: doc/BRIEF.md
# Burst Block Fetcher with Pixel Unpacking

This block moves one data partition from an external memory into the input queue of a processing element. A single command supplies a base word address and a block length counted in pixels. The block issues one read request for the whole partition and receives the words of that burst. After an initial access latency, the memory returns one word per cycle. Each word carries several narrow pixels. The block splits every word into its pixels and pushes them one per cycle into a downstream FIFO.

The transfer is atomic. Exactly one request covers the whole partition, and a second command cannot split or interleave it while it is in flight. When the downstream FIFO is full it drops its ready signal. The unpacker then stops taking words from the memory, which holds the burst word stream through a ready signal on the read port, so no pixel is lost. A one-cycle completion pulse marks the cycle after the last pixel of the block has been taken. A command whose length cannot be split into whole words is refused with a one-cycle error pulse.

Top module: `blk_fetch_unpack`

## Requirements
- R1: After reset, busy, done, cmd_err, mem_req, mem_rready and pix_valid are all low.
- R2: An accepted command produces exactly one mem_req pulse, one cycle long, in the cycle after the command. It carries mem_addr equal to cmd_addr and mem_words equal to cmd_len divided by the pixels per word.
- R3: Pixel k of a word (k = 0 first) is word bits [8k+7:8k], so the least significant byte leaves first. Words leave in increasing address order starting at the base address.
- R4: Every pixel of the block appears on the pixel port exactly once and in order, under any pattern of pix_ready. While the unpacker still holds undelivered pixels, mem_rready is low.
- R5: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data stays unchanged in the next cycle.
- R6: done is high for exactly one cycle: the cycle after the last pixel of the block is accepted. busy is low in that cycle.
- R7: A command with cmd_len zero, or cmd_len not a multiple of four, raises cmd_err for one cycle in the next cycle and issues no memory request.
- R8: A command presented while busy is high is ignored. No request is issued, no error is raised, and the pixels of the running block are unchanged.
- R9: With pix_ready held high and memory words arriving back to back, the pixels of a block leave on consecutive cycles. The last pixel is accepted cmd_len-1 cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start command strobe |
| cmd_addr | input | 16 | Base word address of the block |
| cmd_len | input | 12 | Block length in pixels |
| busy | output | 1 | A block transfer is in progress |
| cmd_err | output | 1 | One-cycle pulse: command refused (bad length) |
| done | output | 1 | One-cycle pulse after the last pixel is accepted |
| mem_req | output | 1 | Burst read request, one cycle |
| mem_addr | output | 16 | Burst start word address |
| mem_words | output | 12 | Burst length in words |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| mem_rready | output | 1 | Unpacker can take a word this cycle |
| pix_valid | output | 1 | Pixel valid toward the FIFO |
| pix_data | output | 8 | Pixel value |
| pix_ready | input | 1 | FIFO not full |

## Verification
The bench builds the block with 32-bit words and 8-bit pixels, which gives four lanes per word, a 16-bit address and a 12-bit length. A behavioural memory with a 30-cycle initial latency drives the read port. Four lanes bring lane wrap-around within reach on every word. The shortest legal block, one word, makes the first and last lane of the burst coincide. The 30-cycle latency leaves a long window in which a second command can be tried against a busy block. The bench varies pix_ready three ways: held high, pseudo-random, and high one cycle in four. This exercises gap-free streaming, the word hold-off on the memory side, and pixel hold under stall.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_STREAM = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/fetch_ctrl.sv
`timescale 1ns/1ps
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LW   = 12,
    parameter int LANES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          pix_pop,
    output logic          busy,
    output logic          cmd_err,
    output logic          done,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_words,
    output logic          stream_en
);
    localparam int SH = $clog2(LANES);

    typedef struct packed {
        fetch_state_e  state;
        logic [AW-1:0] addr;
        logic [LW-1:0] words;
        logic [LW-1:0] pix_left;
        logic          done;
        logic          err;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_len == '0 || cmd_len[SH-1:0] != '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.addr     = cmd_addr;
                        d.words    = cmd_len >> SH;
                        d.pix_left = cmd_len;
                        d.state    = ST_REQ;
                    end
                end
            end
            ST_REQ: d.state = ST_STREAM;
            ST_STREAM: begin
                if (pix_pop) begin
                    d.pix_left = q.pix_left - 1'b1;
                    if (q.pix_left == LW'(1)) begin
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, addr: '0, words: '0, pix_left: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != ST_IDLE);
    assign cmd_err   = q.err;
    assign done      = q.done;
    assign mem_req   = (q.state == ST_REQ);
    assign mem_addr  = q.addr;
    assign mem_words = q.words;
    assign stream_en = (q.state == ST_STREAM);

    // R2: the request lasts a single cycle
    p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R6: completion is a one-cycle pulse with the block idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: a refused command leaves the block idle and issues nothing
    p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!busy && !mem_req));
    // R4: pixels only leave while a burst is streaming
    p_pop_streaming_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_pop |-> stream_en);
endmodule

// File: rtl/word_unpack.sv
`timescale 1ns/1ps
module word_unpack #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_en,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    input  logic              pix_ready
);
    localparam int LANES  = WORD_W / PIX_W;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic              full;
    } unp_t;

    unp_t q, d;
    logic pop, at_last, load;
    logic [PIX_W-1:0] lane_pix [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_pix[g] = q.word[g*PIX_W +: PIX_W];
    end

    always_comb begin
        pop        = q.full && pix_ready;
        at_last    = (q.lane == LAST);
        mem_rready = stream_en && (!q.full || (pop && at_last));
        load       = mem_rvalid && mem_rready;
        d = q;
        if (pop) begin
            if (at_last) begin
                d.full = 1'b0;
                d.lane = '0;
            end else begin
                d.lane = q.lane + 1'b1;
            end
        end
        if (load) begin
            d.word = mem_rdata;
            d.full = 1'b1;
            d.lane = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{word: '0, lane: '0, full: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pix_valid = q.full;
    assign pix_data  = lane_pix[q.lane];

    // R5: a stalled pixel stays put
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));
    // R3: a word keeps supplying pixels until its last lane has gone
    p_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && q.lane != LAST) |=> pix_valid);
    // R4: a held word is never overwritten before it is drained
    p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !pix_ready) |=> $stable(q.word));
endmodule

// File: rtl/blk_fetch_unpack.sv
`timescale 1ns/1ps
module blk_fetch_unpack #(
    parameter int AW     = 16,
    parameter int LW     = 12,
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [LW-1:0]     cmd_len,
    output logic              busy,
    output logic              cmd_err,
    output logic              done,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [LW-1:0]     mem_words,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    input  logic              pix_ready
);
    localparam int LANES = WORD_W / PIX_W;

    logic stream_en;
    logic pix_pop;

    assign pix_pop = pix_valid && pix_ready;

    fetch_ctrl #(.AW(AW), .LW(LW), .LANES(LANES)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .pix_pop   (pix_pop),
        .busy      (busy),
        .cmd_err   (cmd_err),
        .done      (done),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_words (mem_words),
        .stream_en (stream_en)
    );

    word_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) i_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_en  (stream_en),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rready (mem_rready),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_ready  (pix_ready)
    );

    // R1: nothing moves out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req && !pix_valid));
endmodule

// File: tb/test_blk_fetch_unpack.sv
`timescale 1ns/1ps
module test_blk_fetch_unpack;
    localparam int LAT = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [11:0] cmd_len = '0;
    logic        busy, cmd_err, done, mem_req, mem_rready, pix_valid;
    logic [15:0] mem_addr;
    logic [11:0] mem_words;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  pix_data;
    logic        pix_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ready_mode = 0;
    int blocks_done = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]  exp_pix[$];
    int          exp_len[$];
    logic [27:0] exp_req[$];

    always #5 clk = ~clk;

    blk_fetch_unpack i_blk_fetch_unpack (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .busy(busy), .cmd_err(cmd_err), .done(done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_words(mem_words),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready)
    );

    function automatic logic [31:0] mem_word(int a);
        return 32'(a) * 32'h0103_0507 + 32'h5A3C_0F11;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural burst memory
    int cur_a = 0, left_w = 0, lat_cnt = 0;
    bit active = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            active <= 0;
        end else if (mem_req) begin
            cur_a <= int'(mem_addr);
            left_w <= int'(mem_words);
            lat_cnt <= LAT;
            active <= 1;
        end else if (active) begin
            if (!mem_rvalid) begin
                if (lat_cnt <= 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata <= mem_word(cur_a);
                end else lat_cnt <= lat_cnt - 1;
            end else if (mem_rready) begin
                if (left_w == 1) begin
                    mem_rvalid <= 1'b0;
                    active <= 0;
                end else begin
                    cur_a <= cur_a + 1;
                    left_w <= left_w - 1;
                    mem_rdata <= mem_word(cur_a + 1);
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        int cur_left = 0;
        int first_cyc = 0;
        int blk_len = 0;
        bit pend_done = 0;
        bit stalled = 0;
        logic [7:0] held = '0;
        logic [27:0] r;
        wait (rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0: pix_ready = 1'b1;
                1: pix_ready = lfsr[0];
                default: pix_ready = (cyc % 4 == 0);
            endcase
            #1;
            if (done || pend_done) begin
                check(done == pend_done, "R6 done timing", done, pend_done);
                if (done) check(!busy, "R6 busy low at done", busy, 0);
            end
            if (pend_done) blocks_done++;
            pend_done = 0;
            if (stalled) begin
                check(pix_valid && pix_data == held, "R5 hold", pix_data, held);
            end
            stalled = pix_valid && !pix_ready;
            held = pix_data;
            if (mem_req) begin
                if (exp_req.size() == 0) begin
                    check(0, "R8 unexpected request", {4'h0, mem_addr, mem_words}, 0);
                end else begin
                    r = exp_req.pop_front();
                    check({mem_addr, mem_words} == r, "R2 request addr/words", {4'h0, mem_addr, mem_words}, {4'h0, r});
                end
            end
            if (pix_valid && pix_ready) begin
                if (cur_left == 0) begin
                    if (exp_len.size() > 0) begin
                        cur_left = exp_len.pop_front();
                        blk_len = cur_left;
                    end
                    first_cyc = cyc;
                end
                if (exp_pix.size() == 0) begin
                    check(0, "R4 extra pixel", pix_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_pix.pop_front();
                    check(pix_data == e, "R3 pixel value/order", pix_data, e);
                end
                cur_left--;
                if (cur_left == 0) begin
                    pend_done = 1;
                    if (ready_mode == 0)
                        check(cyc - first_cyc == blk_len - 1, "R9 gap-free stream", cyc - first_cyc, blk_len - 1);
                end
            end
        end
    end

    task automatic start(input int addr, input int len, input bit exp_err, input bit accept);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr = 16'(addr);
        cmd_len = 12'(len);
        if (accept) begin
            exp_req.push_back({16'(addr), 12'(len / 4)});
            exp_len.push_back(len);
            for (int w = 0; w < len / 4; w++) begin
                logic [31:0] wd;
                wd = mem_word(addr + w);
                for (int k = 0; k < 4; k++) exp_pix.push_back(wd[8*k +: 8]);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == exp_err, exp_err ? "R7 error pulse" : "R8 no error", cmd_err, exp_err);
    endtask

    task automatic wait_blocks(input int n);
        while (blocks_done < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!busy && !done && !cmd_err && !mem_req && !mem_rready && !pix_valid,
              "R1 reset state", {busy, done, cmd_err, mem_req, mem_rready, pix_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!busy && !pix_valid && !mem_rready, "R1 after release", {busy, pix_valid, mem_rready}, 0);

        ready_mode = 0;
        start(16'h20, 0, 1, 0);
        start(16'h20, 6, 1, 0);
        @(negedge clk);
        #2;
        check(!cmd_err, "R7 error is one cycle", cmd_err, 0);

        start(16'h10, 16, 0, 1);
        wait_blocks(1);

        ready_mode = 1;
        start(16'h40, 32, 0, 1);
        repeat (5) @(negedge clk);
        start(16'h99, 8, 0, 0);
        wait_blocks(2);

        ready_mode = 0;
        start(16'h3FF, 4, 0, 1);
        wait_blocks(3);

        ready_mode = 2;
        start(16'h200, 64, 0, 1);
        wait_blocks(4);

        ready_mode = 0;
        start(16'h500, 40, 0, 1);
        wait_blocks(5);

        check(exp_pix.size() == 0, "R4 all pixels delivered", exp_pix.size(), 0);
        check(exp_req.size() == 0, "R2 all requests seen", exp_req.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule